// File: doc/BRIEF.md
# Single-Channel Triggered DMA Mover

This block is one DMA channel that copies words from a memory read port to a peripheral register through a write port. Software loads a transfer descriptor on the configuration pins and pulses `en_set`. The descriptor holds the source and destination addresses, the element count per frame, the frame count per block, an increment-or-fixed choice for each address, the access sizes, the transfer type and the trigger mode. The channel then waits for triggers.

A trigger is either a software pulse or, in hardware mode, a rising edge on one line of the request vector. The line is picked by a request-select field. In frame-transfer mode each trigger moves one frame. In block-transfer mode one trigger moves the whole block. When the last element of the last frame is written, the channel disables itself and raises a sticky interrupt. Writing a one to `irq_clr` clears that interrupt.

The read and write ports are valid/ready. A read request holds `rd_valid` and `rd_addr` until `rd_ready` is seen high on a clock edge. The read data comes back later as a single-cycle `rd_rvalid` pulse, and only one read is ever outstanding. A write holds `wr_valid`, `wr_addr` and `wr_data` until `wr_ready` is seen high. A low ready stalls the channel without losing anything.

Top module: `xfer_dma_channel`

## Requirements
- R1: After reset `ch_en`, `irq`, `rd_valid` and `wr_valid` are all 0.
- R2: The k-th write (k from 0) carries the word read from `src + k*rstep` and goes to `dst + k*wstep`. Here rstep is the read step and wstep the write step, and each step is 0 when its increment bit is 0. A step follows its size code: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes.
- R3: With `cfg_frame_mode`=0 (block transfer), one trigger produces exactly elcnt*frcnt writes with no further trigger.
- R4: With `cfg_frame_mode`=1 (frame transfer), one trigger produces exactly elcnt writes. The channel then makes no further access until another trigger arrives.
- R5: With `cfg_hw_mode`=1, a 0-to-1 change on `req_in[cfg_req_sel]` is a trigger. Changes on other lines have no effect. With `cfg_hw_mode`=0 the request lines have no effect. `sw_trig` triggers in both modes.
- R6: Triggers that arrive while a frame is in progress are latched as a single pending trigger. That trigger starts the next frame when the current one ends, so two or more such triggers yield one extra frame.
- R7: `irq` rises and `ch_en` falls on the clock edge that completes the last write handshake of the block.
- R8: `irq` stays 1 until a cycle with `irq_clr`=1, after which it reads 0.
- R9: `en_set` while `ch_en`=1 is ignored, so the descriptor is kept. Triggers while `ch_en`=0 cause no access.
- R10: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` and `rd_addr` hold. While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` hold. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_elcnt | input | ELW | Elements per frame (0 treated as 1) |
| cfg_frcnt | input | FRW | Frames per block (0 treated as 1) |
| cfg_rd_inc | input | 1 | 1: source address advances per element |
| cfg_wr_inc | input | 1 | 1: destination address advances per element |
| cfg_rd_size | input | 2 | Read size code (0/1/2 = 1/2/4 bytes) |
| cfg_wr_size | input | 2 | Write size code (0/1/2 = 1/2/4 bytes) |
| cfg_frame_mode | input | 1 | 1: frame per trigger, 0: block per trigger |
| cfg_hw_mode | input | 1 | 1: hardware request lines trigger |
| cfg_req_sel | input | SELW | Request line routed to the channel |
| en_set | input | 1 | Load descriptor and enable channel |
| sw_trig | input | 1 | Software trigger pulse |
| req_in | input | NREQ | Hardware request lines |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_rvalid | input | 1 | Read data valid (one cycle) |
| rd_rdata | input | DW | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | DW | Write data |
| ch_en | output | 1 | Channel enabled |
| irq | output | 1 | Block-complete interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |

## Verification
The bench checks that frame mode stops after exactly one frame. A channel that ran on through the block, as a wrongly decoded transfer type would, overruns the peripheral and shows up as an excess write count. It pulses unselected request lines, and pulses the selected line while in software mode, to catch a mux or mode gate that leaks triggers. It also fires three request edges inside one frame and expects one extra frame, not zero and not three, which catches both a dropped pending trigger and a queue of pending triggers. Every write is compared against the address and data the bench computes from the descriptor under random ready stalls. A reload while enabled must not disturb the running block, and the interrupt is checked in the cycle after the final handshake.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_RWAIT,
    ST_WRITE
  } xd_state_e;

  typedef struct packed {
    logic       frame_mode;
    logic       hw_mode;
    logic       rd_inc;
    logic       wr_inc;
    logic [1:0] rd_size;
    logic [1:0] wr_size;
  } xd_mode_t;

  function automatic logic [2:0] xd_step(input logic [1:0] sz);
    if (sz[1]) return 3'd4;
    else if (sz[0]) return 3'd2;
    else return 3'd1;
  endfunction

endpackage

// File: rtl/xfer_dma_req_route.sv
module xfer_dma_req_route #(
  parameter int NREQ = 32,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_in,
  input  logic [SELW-1:0] sel,
  output logic            hw_rise
);
  logic [NREQ-1:0] req_q;
  logic [NREQ-1:0] rise;

  for (genvar i = 0; i < NREQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= req_in[i];
    end
    assign rise[i] = req_in[i] & ~req_q[i];
  end

  always_comb begin
    hw_rise = 1'b0;
    for (int j = 0; j < NREQ; j++) begin
      if (SELW'(j) == sel) hw_rise = rise[j];
    end
  end
endmodule

// File: rtl/xfer_dma_addr_walk.sv
module xfer_dma_addr_walk
  import xfer_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          inc,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)         addr <= '0;
    else if (load)      addr <= base;
    else if (adv && inc) addr <= addr + AW'(xd_step(size));
  end
endmodule

// File: rtl/xfer_dma_count.sv
module xfer_dma_count #(
  parameter int ELW = 16,
  parameter int FRW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [ELW-1:0] el_init,
  input  logic [FRW-1:0] fr_init,
  input  logic           adv,
  output logic           el_last,
  output logic           fr_last
);
  logic [ELW-1:0] el_left, el_reload;
  logic [FRW-1:0] fr_left;

  assign el_last = (el_left <= ELW'(1));
  assign fr_last = (fr_left <= FRW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_left   <= '0;
      el_reload <= '0;
      fr_left   <= '0;
    end else if (load) begin
      el_left   <= el_init;
      el_reload <= el_init;
      fr_left   <= fr_init;
    end else if (adv) begin
      if (el_last) begin
        el_left <= el_reload;
        fr_left <= fr_left - FRW'(1);
      end else begin
        el_left <= el_left - ELW'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_dma_channel.sv
module xfer_dma_channel
  import xfer_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int ELW  = 16,
  parameter int FRW  = 16,
  parameter int NREQ = 32,
  localparam int SELW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [ELW-1:0]  cfg_elcnt,
  input  logic [FRW-1:0]  cfg_frcnt,
  input  logic            cfg_rd_inc,
  input  logic            cfg_wr_inc,
  input  logic [1:0]      cfg_rd_size,
  input  logic [1:0]      cfg_wr_size,
  input  logic            cfg_frame_mode,
  input  logic            cfg_hw_mode,
  input  logic [SELW-1:0] cfg_req_sel,
  input  logic            en_set,
  input  logic            sw_trig,
  input  logic [NREQ-1:0] req_in,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  output logic [1:0]      rd_size,
  input  logic            rd_rvalid,
  input  logic [DW-1:0]   rd_rdata,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [1:0]      wr_size,
  output logic [DW-1:0]   wr_data,
  output logic            ch_en,
  output logic            irq,
  input  logic            irq_clr
);
  xd_state_e       st;
  xd_mode_t        mode_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   data_q;
  logic            pend_q;
  logic            hw_rise, load, trig, wr_fire, el_last, fr_last, done;

  assign load    = en_set && !ch_en;
  assign trig    = ch_en && (sw_trig || (mode_q.hw_mode && hw_rise));
  assign wr_fire = (st == ST_WRITE) && wr_ready;
  assign done    = wr_fire && el_last && fr_last;

  assign rd_valid = (st == ST_READ);
  assign wr_valid = (st == ST_WRITE);
  assign wr_data  = data_q;
  assign rd_size  = mode_q.rd_size;
  assign wr_size  = mode_q.wr_size;

  xfer_dma_req_route #(.NREQ(NREQ), .SELW(SELW)) u_route (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .sel(sel_q), .hw_rise(hw_rise)
  );

  xfer_dma_addr_walk #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_src), .adv(wr_fire),
    .inc(mode_q.rd_inc), .size(mode_q.rd_size), .addr(rd_addr)
  );

  xfer_dma_addr_walk #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_dst), .adv(wr_fire),
    .inc(mode_q.wr_inc), .size(mode_q.wr_size), .addr(wr_addr)
  );

  xfer_dma_count #(.ELW(ELW), .FRW(FRW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .el_init(cfg_elcnt),
    .fr_init(cfg_frcnt), .adv(wr_fire), .el_last(el_last), .fr_last(fr_last)
  );

  // descriptor capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else if (load) begin
      mode_q <= '{frame_mode: cfg_frame_mode, hw_mode: cfg_hw_mode,
                  rd_inc: cfg_rd_inc, wr_inc: cfg_wr_inc,
                  rd_size: cfg_rd_size, wr_size: cfg_wr_size};
      sel_q  <= cfg_req_sel;
    end
  end

  // sequencer, pending trigger, enable and interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pend_q <= 1'b0;
      ch_en  <= 1'b0;
      irq    <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) begin
        ch_en  <= 1'b1;
        pend_q <= 1'b0;
      end
      if (irq_clr) irq <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ch_en && (trig || pend_q)) begin
            st     <= ST_READ;
            pend_q <= 1'b0;
          end
        end
        ST_READ: begin
          if (trig) pend_q <= 1'b1;
          if (rd_ready) st <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (trig) pend_q <= 1'b1;
          if (rd_rvalid) begin
            data_q <= rd_rdata;
            st     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (trig) pend_q <= 1'b1;
          if (wr_ready) begin
            if (done) begin
              st     <= ST_IDLE;
              ch_en  <= 1'b0;
              irq    <= 1'b1;
              pend_q <= 1'b0;
            end else if (el_last && mode_q.frame_mode) begin
              st <= ST_IDLE;
            end else begin
              st <= ST_READ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_dma_channel_chk.sv
module xfer_dma_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          irq,
  input logic          irq_clr,
  input logic          ch_en
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_valid && wr_ready) && !ch_en);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !wr_valid |=> !irq);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !rd_valid && !wr_valid);
endmodule

bind xfer_dma_channel xfer_dma_channel_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/xfer_dma_channel_bench.sv
module xfer_dma_channel_bench;
  localparam int AW = 32, DW = 32, ELW = 16, FRW = 16, NREQ = 32, SELW = 5;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [ELW-1:0] cfg_elcnt = 0;
  logic [FRW-1:0] cfg_frcnt = 0;
  logic cfg_rd_inc = 0, cfg_wr_inc = 0, cfg_frame_mode = 0, cfg_hw_mode = 0;
  logic [1:0] cfg_rd_size = 0, cfg_wr_size = 0;
  logic [SELW-1:0] cfg_req_sel = 0;
  logic en_set = 0, sw_trig = 0, irq_clr = 0;
  logic [NREQ-1:0] req_in = 0;
  logic rd_valid, rd_ready = 0, rd_rvalid = 0, wr_valid, wr_ready = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_rdata = 0, wr_data;
  logic [1:0] rd_size, wr_size;
  logic ch_en, irq;

  xfer_dma_channel u_xfer_dma_channel (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, total = 0;
  bit rnd_ready = 0, irq_due = 0, resp_pend = 0, stall_prev = 0;
  logic [DW-1:0] resp_data, prev_wd;
  logic [AW-1:0] prev_wa;
  logic [AW-1:0] e_src, e_dst;
  bit e_ri, e_wi;
  logic [1:0] e_rs, e_ws;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [AW-1:0] exp_src(input int k);
    return e_ri ? e_src + AW'(k) * step_of(e_rs) : e_src;
  endfunction

  function automatic logic [AW-1:0] exp_dst(input int k);
    return e_wi ? e_dst + AW'(k) * step_of(e_ws) : e_dst;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // port model: ready drivers, read responder, write scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_due) begin
        chk(irq == 1'b1, "R7", "irq after last write", irq, 1);
        chk(ch_en == 1'b0, "R7", "ch_en after last write", ch_en, 0);
        irq_due = 0;
      end
      rd_rvalid = resp_pend;
      rd_rdata  = resp_data;
      resp_pend = 0;
      if (stall_prev) begin
        chk(wr_valid && wr_addr == prev_wa && wr_data == prev_wd, "R10",
            "write held under stall", wr_data, prev_wd);
      end
      rd_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      wr_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        resp_pend = 1;
        resp_data = mem_word(rd_addr);
      end
      if (wr_valid && wr_ready) begin
        chk(wr_addr == exp_dst(wr_cnt), "R2", "write address", wr_addr, exp_dst(wr_cnt));
        chk(wr_data == mem_word(exp_src(wr_cnt)), "R2", "write data", wr_data,
            mem_word(exp_src(wr_cnt)));
        wr_cnt++;
        if (wr_cnt == total) irq_due = 1;
      end
      stall_prev = wr_valid && !wr_ready;
      prev_wa = wr_addr;
      prev_wd = wr_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable_ch(input logic [AW-1:0] src, dst, input int el, fr,
                           input bit ri, wi, input logic [1:0] rs, ws,
                           input bit fm, hm, input int sel);
    @(negedge clk);
    cfg_src = src; cfg_dst = dst; cfg_elcnt = ELW'(el); cfg_frcnt = FRW'(fr);
    cfg_rd_inc = ri; cfg_wr_inc = wi; cfg_rd_size = rs; cfg_wr_size = ws;
    cfg_frame_mode = fm; cfg_hw_mode = hm; cfg_req_sel = SELW'(sel);
    e_src = src; e_dst = dst; e_ri = ri; e_wi = wi; e_rs = rs; e_ws = ws;
    wr_cnt = 0; total = el * fr;
    en_set = 1;
    @(negedge clk);
    en_set = 0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask

  task automatic pulse_req(input int i);
    @(negedge clk); req_in[i] = 1;
    @(negedge clk); req_in[i] = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && ch_en; i++) @(negedge clk);
    cycles(2);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cycles(4);
    chk(ch_en == 0 && irq == 0, "R1", "ch_en/irq in reset", {ch_en, irq}, 0);
    chk(rd_valid == 0 && wr_valid == 0, "R1", "valids in reset", {rd_valid, wr_valid}, 0);
    rst_n = 1;
    cycles(2);

    // R9: trigger while disabled does nothing
    pulse_sw();
    cycles(20);
    chk(wr_cnt == 0, "R9", "writes with channel disabled", wr_cnt, 0);

    // R3 block transfer, fixed peripheral destination; R9 reload ignored
    enable_ch(32'h1000, 32'h4000_0010, 1, 8, 1, 0, 2, 2, 0, 0, 0);
    @(negedge clk); cfg_src = 32'hDEAD_0000; en_set = 1;
    @(negedge clk); en_set = 0;
    pulse_sw();
    wait_done();
    chk(wr_cnt == 8, "R3", "block write count", wr_cnt, 8);
    chk(ch_en == 0, "R9", "channel off after block", ch_en, 0);
    cycles(5);
    chk(irq == 1, "R8", "irq held before clear", irq, 1);
    clear_irq();

    // R2 R3 random descriptors with random stalls
    rnd_ready = 1;
    for (int it = 0; it < 8; it++) begin
      enable_ch({$urandom_range(0, 65535), 2'b00}, $urandom,
                $urandom_range(1, 4), $urandom_range(1, 4),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
                0, 1'($urandom_range(0, 1)), 3);
      pulse_sw();
      wait_done();
      chk(wr_cnt == total, "R3", "random block count", wr_cnt, total);
      clear_irq();
    end

    // R5 block mode started by a hardware edge
    enable_ch(32'h2000, 32'h4000_0020, 2, 3, 1, 1, 1, 2, 0, 1, 9);
    pulse_req(9);
    wait_done();
    chk(wr_cnt == 6, "R5", "hardware-started block", wr_cnt, 6);
    clear_irq();

    // R4 R5 R6 frame mode with hardware requests
    enable_ch(32'h3000, 32'h4000_0030, 3, 5, 1, 0, 2, 2, 1, 1, 5);
    pulse_sw();
    cycles(200);
    chk(wr_cnt == 3, "R4", "one frame per trigger", wr_cnt, 3);
    pulse_req(6);
    cycles(100);
    chk(wr_cnt == 3, "R5", "unselected line ignored", wr_cnt, 3);
    pulse_req(5);
    cycles(200);
    chk(wr_cnt == 6, "R5", "selected line triggers frame", wr_cnt, 6);
    pulse_req(5);
    pulse_req(5);
    pulse_req(5);
    cycles(300);
    chk(wr_cnt == 12, "R6", "pending collapses to one frame", wr_cnt, 12);
    chk(ch_en == 1, "R6", "channel still enabled", ch_en, 1);
    pulse_req(5);
    wait_done();
    chk(wr_cnt == 15, "R4", "frames complete block", wr_cnt, 15);
    clear_irq();

    // R5 software mode ignores request lines
    enable_ch(32'h5000, 32'h4000_0040, 2, 2, 1, 1, 2, 2, 1, 0, 4);
    pulse_req(4);
    cycles(50);
    chk(wr_cnt == 0, "R5", "request ignored in software mode", wr_cnt, 0);
    pulse_sw();
    cycles(100);
    chk(wr_cnt == 2, "R4", "software frame", wr_cnt, 2);
    pulse_sw();
    wait_done();
    chk(wr_cnt == 4, "R4", "second software frame", wr_cnt, 4);
    clear_irq();

    cycles(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule